// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the software-visible register front end of an I/O interrupt controller. A processor reaches all of the controller's configuration through three word offsets: an index register, a data window, and a direct end-of-interrupt register. The index register selects what the window shows. That can be an identification register, a version register, an arbitration register (which reads back the identification value), or one 32-bit half of any of the redirection entries. Each redirection entry is 64 bits wide.

The whole redirection table is driven out in parallel to the delivery logic that sits beside this block. Every accepted table write raises a one-cycle rescan pulse so the delivery logic can re-evaluate pending inputs. A write to the end-of-interrupt register produces a strobe that carries the written vector, but only for controller version 0x20. The delivery logic reports level-triggered acceptance back through a per-entry remote-IRR set input. The block itself delivers no interrupts.

Top module: `intc_regwin`

## Requirements
- R1: After a synchronous reset every entry holds 64'h0000_0000_0001_0000, with only the mask bit 16 set. The index register and the 4-bit ID both hold zero.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the 8-bit index register, which takes bus_wdata[7:0] and reads back zero-extended at any size. Offset 0x10 is the data window and offset 0x40 is the EOI register. Address bits above bit 7 are ignored.
- R3: A window access with a size other than 4 bytes has no effect. A write through it changes no state and a read through it returns zero.
- R4: Index 0x00 and index 0x02 both read the ID in bits 27:24. A write to index 0x00 stores bus_wdata[27:24] and nothing else. Writes to index 0x01 and index 0x02 are discarded.
- R5: Index 0x01 reads VERSION in bits 7:0 and NPINS-1 in bits 23:16, with all other bits zero.
- R6: Index 0x10+2n reaches entry n. An even index selects bits 31:0 and an odd index selects bits 63:32. An index outside the table, or any other undefined index, reads zero and ignores writes.
- R7: An entry write changes only the writable bits, which are mask 64'hFFFF_0000_0001_AFFF. Delivery status (bit 12) and remote IRR (bit 14) keep their previous values, and the reserved bits 47:17 stay zero.
- R8: After an entry write, if trigger mode bit 15 is 0 (edge), remote IRR is cleared. If bit 15 is 1 (level), remote IRR is kept. A rirr_set[n] pulse sets remote IRR of entry n.
- R9: rescan is high for exactly the one cycle after each accepted entry write, and low after any other access.
- R10: A 4-byte write to offset 0x40 raises eoi_pulse for one cycle on the next cycle, with eoi_vector equal to bus_wdata[7:0], only when VERSION is 0x20. With VERSION 0x11, or with any other size, nothing is raised.
- R11: VERSION must be 0x11 or 0x20.
- R12: bus_rdata is loaded on the clock edge that samples bus_rd and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address inside the 4 KiB region |
| bus_size | input | 3 | Access size in bytes |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NPINS | Per-entry remote-IRR set from delivery logic |
| tbl_out | output | NPINS x 64 | Redirection entries |
| rescan | output | 1 | Table-changed pulse |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector carried by the strobe |

## Verification
A corrupted entry register appears on tbl_out on the very next cycle. It is also returned through the window one cycle after the read request. A lost read-only bit shows the same way as soon as the entry is rewritten, because the merge writes back whatever was stored. A wrong index decode shows up on the following window access in one of two ways: the wrong entry changes on tbl_out, or rescan is missing. A wrong EOI gate shows as a strobe, or as the lack of one, one cycle after the EOI write.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
  localparam logic [7:0]  OFS_INDEX  = 8'h00;
  localparam logic [7:0]  OFS_WINDOW = 8'h10;
  localparam logic [7:0]  OFS_EOI    = 8'h40;
  localparam logic [7:0]  IX_ID      = 8'h00;
  localparam logic [7:0]  IX_VER     = 8'h01;
  localparam logic [7:0]  IX_ARB     = 8'h02;
  localparam logic [7:0]  IX_TBASE   = 8'h10;
  localparam logic [63:0] ENT_RW     = 64'hFFFF_0000_0001_AFFF;
  localparam logic [63:0] ENT_RESET  = 64'h0000_0000_0001_0000;
  localparam int          B_DSTAT    = 12;
  localparam int          B_RIRR     = 14;
  localparam int          B_TRIG     = 15;
  localparam int          ID_LSB     = 24;
  localparam int          ID_W       = 4;
  localparam int          MAXENT_LSB = 16;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_regwin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NPINS  = 24,
  localparam int ENT_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [7:0]        index,
  output logic              hit_index,
  output logic              hit_window,
  output logic              hit_eoi,
  output logic              word_ok,
  output logic              sel_id,
  output logic              sel_ver,
  output logic              sel_arb,
  output logic              sel_entry,
  output logic [ENT_W-1:0]  entry_num,
  output logic              upper_half
);
  localparam int TOP_IX = 16 + 2 * NPINS;
  logic [7:0] low_addr;
  logic [7:0] rel;

  always_comb begin
    low_addr   = addr[7:0];
    hit_index  = (low_addr == OFS_INDEX);
    hit_window = (low_addr == OFS_WINDOW);
    hit_eoi    = (low_addr == OFS_EOI);
    word_ok    = (size == 3'd4);
    sel_id     = (index == IX_ID);
    sel_ver    = (index == IX_VER);
    sel_arb    = (index == IX_ARB);
    rel        = index - IX_TBASE;
    sel_entry  = (index >= IX_TBASE) && (int'(index) < TOP_IX);
    entry_num  = rel[ENT_W:1];
    upper_half = index[0];
  end
endmodule

// File: rtl/intc_redir_table.sv
module intc_redir_table
  import intc_regwin_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       we,
  input  logic                   upper,
  input  logic [31:0]            wdata,
  input  logic [NPINS-1:0]       rirr_set,
  output logic [NPINS-1:0][63:0] tbl
);
  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [63:0] merged;
    logic [63:0] next_e;

    always_comb begin
      merged = upper ? {wdata, tbl[g][31:0]} : {tbl[g][63:32], wdata};
      next_e = (merged & ENT_RW) | (tbl[g] & ~ENT_RW);
      if (!next_e[B_TRIG]) next_e[B_RIRR] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[g] <= ENT_RESET;
      end else begin
        if (we[g]) tbl[g] <= next_e | ({63'd0, rirr_set[g]} << B_RIRR);
        else if (rirr_set[g]) tbl[g][B_RIRR] <= 1'b1;
      end
    end

    // R7: delivery status survives a write
    p_dstat_kept_r7: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> tbl[g][B_DSTAT] == $past(tbl[g][B_DSTAT]));
    // R8: edge entries leave a write with remote IRR clear
    p_edge_clears_rirr_r8: assert property (@(posedge clk) disable iff (rst)
      (we[g] && !rirr_set[g]) |=> (tbl[g][B_TRIG] || !tbl[g][B_RIRR]));
    // R7: reserved bits never become set
    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> tbl[g][47:17] == 31'd0);
  end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int         ADDR_W  = 12,
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [2:0]             bus_size,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NPINS-1:0]       rirr_set,
  output logic [NPINS-1:0][63:0] tbl_out,
  output logic                   rescan,
  output logic                   eoi_pulse,
  output logic [7:0]             eoi_vector
);
  localparam int  ENT_W    = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam bit  EOI_ON   = (VERSION == 8'h20);
  localparam logic [7:0] MAXENT = 8'(NPINS - 1);

  initial begin
    // R11: only the two supported versions
    p_version_ok_r11: assert (VERSION == 8'h11 || VERSION == 8'h20);
  end

  logic [7:0]       index_q;
  logic [ID_W-1:0]  id_q;
  logic             hit_index, hit_window, hit_eoi, word_ok;
  logic             sel_id, sel_ver, sel_arb, sel_entry, upper_half;
  logic [ENT_W-1:0] entry_num;
  logic [NPINS-1:0] ent_we;
  logic             win_wr;
  logic [31:0]      rd_val;
  logic [63:0]      rd_ent;

  intc_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_dec (
    .addr(bus_addr), .size(bus_size), .index(index_q),
    .hit_index(hit_index), .hit_window(hit_window), .hit_eoi(hit_eoi),
    .word_ok(word_ok), .sel_id(sel_id), .sel_ver(sel_ver), .sel_arb(sel_arb),
    .sel_entry(sel_entry), .entry_num(entry_num), .upper_half(upper_half)
  );

  assign win_wr = bus_wr && hit_window && word_ok;

  always_comb begin
    ent_we = '0;
    if (win_wr && sel_entry) ent_we[entry_num] = 1'b1;
  end

  intc_redir_table #(.NPINS(NPINS)) u_tbl (
    .clk(clk), .rst(rst), .we(ent_we), .upper(upper_half),
    .wdata(bus_wdata), .rirr_set(rirr_set), .tbl(tbl_out)
  );

  always_comb begin
    rd_ent = sel_entry ? tbl_out[entry_num] : 64'd0;
    rd_val = 32'd0;
    if (hit_index) begin
      rd_val = {24'd0, index_q};
    end else if (hit_window && word_ok) begin
      if (sel_id || sel_arb)  rd_val = {4'd0, id_q, 24'd0};
      else if (sel_ver)       rd_val = {8'd0, MAXENT, 8'd0, VERSION};
      else if (sel_entry)     rd_val = upper_half ? rd_ent[63:32] : rd_ent[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q    <= 8'd0;
      id_q       <= '0;
      bus_rdata  <= 32'd0;
      rescan     <= 1'b0;
      eoi_pulse  <= 1'b0;
      eoi_vector <= 8'd0;
    end else begin
      if (bus_wr && hit_index) index_q <= bus_wdata[7:0];
      if (win_wr && sel_id) id_q <= bus_wdata[ID_LSB +: ID_W];
      if (bus_rd) bus_rdata <= rd_val;
      rescan    <= win_wr && sel_entry;
      eoi_pulse <= EOI_ON && bus_wr && hit_eoi && word_ok;
      if (EOI_ON && bus_wr && hit_eoi && word_ok) eoi_vector <= bus_wdata[7:0];
    end
  end

  // R3: narrow window reads return zero
  p_narrow_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[7:0] == OFS_WINDOW && bus_size != 3'd4) |=> bus_rdata == 32'd0);
  // R9: rescan only follows a write
  p_rescan_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    rescan |-> $past(bus_wr));
  // R10: strobe only after a full-word EOI write
  p_eoi_source_r10: assert property (@(posedge clk) disable iff (rst)
    eoi_pulse |-> $past(bus_wr && bus_addr[7:0] == OFS_EOI && bus_size == 3'd4));
  // R12: read data holds when no read is requested
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/intc_regwin_tb.sv
module intc_regwin_tb;
  localparam int NP = 24;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [NP-1:0] rirr_set = '0;
  logic [31:0] rdata, rdata11;
  logic [NP-1:0][63:0] tbl, tbl11;
  logic rescan, rescan11, eoi, eoi11;
  logic [7:0] eoi_vec, eoi_vec11;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic seen_rescan, seen_eoi, seen_eoi11;
  logic [7:0] seen_vec;

  always #2.5 clk = ~clk;

  intc_regwin #(.ADDR_W(12), .NPINS(NP), .VERSION(8'h20)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata), .rirr_set(rirr_set),
    .tbl_out(tbl), .rescan(rescan), .eoi_pulse(eoi), .eoi_vector(eoi_vec));

  intc_regwin #(.ADDR_W(12), .NPINS(NP), .VERSION(8'h11)) u_dut_v11 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata11), .rirr_set(rirr_set),
    .tbl_out(tbl11), .rescan(rescan11), .eoi_pulse(eoi11), .eoi_vector(eoi_vec11));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    seen_rescan = rescan; seen_eoi = eoi; seen_vec = eoi_vec; seen_eoi11 = eoi11;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata;
  endtask

  task automatic sel(input logic [7:0] ix);
    wr(12'h000, 3'd4, {24'd0, ix});
  endtask

  task automatic win_read(input logic [7:0] ix, output logic [31:0] d);
    sel(ix);
    rd(12'h010, 3'd4, d);
  endtask

  task automatic win_write(input logic [7:0] ix, input logic [31:0] d);
    sel(ix);
    wr(12'h010, 3'd4, d);
  endtask

  task automatic pulse_rirr(input int n);
    @(negedge clk);
    rirr_set = '0; rirr_set[n] = 1'b1;
    @(negedge clk);
    rirr_set = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 entry0", tbl[0], 64'h0000_0000_0001_0000);
    check("R1 entry23", tbl[23], 64'h0000_0000_0001_0000);
    rd(12'h000, 3'd4, d); check("R1 index", {32'd0, d}, 64'd0);
    rd(12'h010, 3'd4, d); check("R1 id", {32'd0, d}, 64'd0);
    win_read(8'h3E, d); check("R1 entry23 low", {32'd0, d}, 64'h0001_0000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(12'h300, 3'd1, 32'hFFFF_FF2A);
    rd(12'hF00, 3'd2, d); check("R2 index alias", {32'd0, d}, 64'h2A);
    rd(12'h0F4, 3'd4, d); check("R2 unused offset", {32'd0, d}, 64'd0);
  endtask

  task automatic t_narrow;
    logic [31:0] d;
    sel(8'h12);
    wr(12'h010, 3'd2, 32'h0000_00FF);
    check("R3 narrow write", tbl[1], 64'h0000_0000_0001_0000);
    check("R3 narrow no rescan", {63'd0, seen_rescan}, 64'd0);
    rd(12'h010, 3'd1, d); check("R3 narrow read", {32'd0, d}, 64'd0);
  endtask

  task automatic t_id_ver;
    logic [31:0] d;
    win_write(8'h00, 32'hFFFF_FFFF);
    check("R9 no rescan on id", {63'd0, seen_rescan}, 64'd0);
    rd(12'h010, 3'd4, d); check("R4 id read", {32'd0, d}, 64'h0F00_0000);
    win_write(8'h02, 32'h0000_0000);
    rd(12'h010, 3'd4, d); check("R4 arb read", {32'd0, d}, 64'h0F00_0000);
    win_write(8'h01, 32'h0000_0000);
    rd(12'h010, 3'd4, d); check("R5 version", {32'd0, d}, 64'h0017_0020);
    check("R11 other version", {32'd0, rdata11}, 64'h0017_0011);
    win_write(8'h00, 32'h0300_0000);
    rd(12'h010, 3'd4, d); check("R4 id rewrite", {32'd0, d}, 64'h0300_0000);
  endtask

  task automatic t_table;
    logic [31:0] d;
    win_write(8'h1A, 32'h0000_8031);
    check("R9 rescan low half", {63'd0, seen_rescan}, 64'd1);
    win_write(8'h1B, 32'hAB00_0000);
    check("R6 entry5", tbl[5], 64'hAB00_0000_0000_8031);
    sel(8'h1B); rd(12'h010, 3'd4, d); check("R6 upper read", {32'd0, d}, 64'hAB00_0000);
    @(negedge clk); @(negedge clk);
    check("R12 hold", {32'd0, rdata}, 64'hAB00_0000);
    win_write(8'h3F, 32'h5500_0000);
    check("R6 last entry", tbl[23], 64'h5500_0000_0001_0000);
    win_write(8'h40, 32'hFFFF_FFFF);
    check("R9 out of range no rescan", {63'd0, seen_rescan}, 64'd0);
    rd(12'h010, 3'd4, d); check("R6 out of range read", {32'd0, d}, 64'd0);
    @(negedge clk);
    check("R9 rescan one cycle", {63'd0, rescan}, 64'd0);
  endtask

  task automatic t_ro_bits;
    logic [31:0] d;
    win_write(8'h16, 32'hFFFF_FFFF);
    rd(12'h010, 3'd4, d); check("R7 rw mask", {32'd0, d}, 64'h0001_AFFF);
    pulse_rirr(3);
    check("R8 rirr set", tbl[3], 64'h0000_0000_0001_EFFF);
    win_write(8'h16, 32'hFFFF_FFFF);
    check("R7 rirr kept on level", tbl[3], 64'h0000_0000_0001_EFFF);
    win_write(8'h16, 32'h0000_0FFF);
    check("R8 edge clears", tbl[3], 64'h0000_0000_0000_0FFF);
    win_write(8'h1C, 32'h0000_8000);
    pulse_rirr(6);
    win_write(8'h1D, 32'h1200_0000);
    check("R8 level upper write keeps", tbl[6], 64'h1200_0000_0000_C000);
    win_write(8'h1E, 32'h0000_0000);
    pulse_rirr(7);
    check("R8 rirr set edge entry", tbl[7], 64'h0000_0000_0000_4000);
    win_write(8'h1F, 32'h3400_0000);
    check("R8 edge upper write clears", tbl[7], 64'h3400_0000_0000_0000);
  endtask

  task automatic t_eoi;
    wr(12'h040, 3'd4, 32'h0000_0155);
    check("R10 eoi pulse", {63'd0, seen_eoi}, 64'd1);
    check("R10 eoi vector", {56'd0, seen_vec}, 64'h55);
    check("R10 v11 no eoi", {63'd0, seen_eoi11}, 64'd0);
    @(negedge clk);
    check("R10 single cycle", {63'd0, eoi}, 64'd0);
    wr(12'h040, 3'd2, 32'h0000_0066);
    check("R10 narrow eoi ignored", {63'd0, seen_eoi}, 64'd0);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_narrow();
    t_id_ver();
    t_table();
    t_ro_bits();
    t_eoi();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule